// File: doc/BRIEF.md
# Local Interrupt Routing Selector

This block picks the single local interrupt a hart should take next, or reports that none is eligible. It merges the raw pending and enable vectors with a virtual-supervisor external bit that it derives from a guest external interrupt vector. It then splits the result into three candidate sets with the machine and hypervisor delegation masks. Each set is gated by an enable that depends on the current privilege, the virtualization mode and the two global interrupt-enable bits.

The sets are examined in a fixed order: machine, then hypervisor-supervisor, then virtual-supervisor. The first set that is not empty decides the outcome. That set's own table of 64 eight-bit priorities chooses the winner inside it. The virtual set is arbitrated on a vector moved down one position, and the winning index is moved back up. A small write port updates the three tables. The chosen interrupt appears on a registered output one clock after the inputs that caused it.

Top module: `irq_route_select`

## Requirements
- R1: The eligible set is (pendVec OR a derived bit at index 10) AND enVec. The derived bit is guestExtVec[guestSel].
- R2: With virtOn low and privilege encoded as 0=user, 1=supervisor, 3=machine: the machine level is enabled when privLvl<3, or when privLvl==3 and mGlobalEn is high. The supervisor level is enabled when privLvl==0, or when privLvl==1 and sGlobalEn is high. The virtual level is disabled.
- R3: With virtOn high, the machine and supervisor levels are always enabled. The virtual level is enabled when privLvl==0, or when privLvl==1 and sGlobalEn is high.
- R4: The candidates of each level are eligible bits filtered by delegation. Machine: NOT mDeleg. Supervisor: mDeleg AND NOT hDeleg. Virtual: mDeleg AND hDeleg.
- R5: The order is machine, then supervisor, then virtual. The first enabled level with a nonempty candidate set decides the result. When no level has candidates, irqValid is 0.
- R6: Within a level, each candidate's effective priority is its table entry. An entry of 0 is replaced by 1 when the interrupt's default rank is below 28, and by 255 otherwise. The smallest effective priority wins, and a tie goes to the lowest interrupt number.
- R7: Virtual candidates are shifted right by one before arbitration, and the shifted index selects the table entry. A winner w>0 is reported as w+1; a winner of 0 is reported as 0. An empty shifted set gives irqValid 0.
- R8: Default rank: 48..63 give 67-i; 24..31 give 51-i; 32..47 give 87-i; 16..23 give 79-i. For the low interrupts: 11:28, 3:29, 7:30, 9:31, 1:32, 5:33, 12:34, 2:36, 6:37, all others 35. On reset, every machine and supervisor entry takes its rank, except machine entry 11 and supervisor entry 9, which reset to 0.
- R9: Virtual entries 1, 5, 13, 14, 15, 16, 18, 20, 22, 24, 26, 28 and 30 reset to their rank and are writable. Every other virtual entry resets to 0 and ignores writes.
- R10: A write with prioWrEn high updates the table chosen by prioWrLvl (0=machine, 1=supervisor, 2=virtual) at prioWrIdx. prioWrLvl 3 is ignored. The new value governs arbitration from the next cycle.
- R11: irqValid and irqNum are registered and follow their inputs by one clock. Both are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendVec | input | 64 | Raw pending interrupts |
| enVec | input | 64 | Per-interrupt enables |
| mDeleg | input | 64 | Machine delegation mask |
| hDeleg | input | 64 | Hypervisor delegation mask |
| privLvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virtOn | input | 1 | Virtualization mode active |
| mGlobalEn | input | 1 | Machine global interrupt enable |
| sGlobalEn | input | 1 | Supervisor global interrupt enable |
| guestExtVec | input | 64 | Guest external interrupt pending vector |
| guestSel | input | 6 | Selects the guest external bit feeding interrupt 10 |
| prioWrEn | input | 1 | Priority table write strobe |
| prioWrLvl | input | 2 | Table select for the write |
| prioWrIdx | input | 6 | Entry index for the write |
| prioWrData | input | 8 | Priority value written |
| irqValid | output | 1 | An interrupt was selected |
| irqNum | output | 6 | Selected interrupt number |

## Verification
Candidates for two or three levels can be present in the same cycle, and level precedence then has to override the priority values. The bench provokes this by raising machine, supervisor and virtual bits together, some of them with priorities better than the eventual winner. It judges the result against an independent model that walks the levels in order. A second collision is a derived guest external bit landing on interrupt 10 while the virtual shift brings another interrupt down to slot 0. Here the model checks that the reported number is the shifted-back winner and never 1.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_IRQ    = 64;
  localparam int IDX_W      = 6;
  localparam int PRIO_W     = 8;
  localparam int LVLS       = 3;
  localparam int LVL_M      = 0;
  localparam int LVL_S      = 1;
  localparam int LVL_V      = 2;
  localparam int VS_EXT_IRQ = 10;
  localparam int M_EXT_IRQ  = 11;
  localparam int S_EXT_IRQ  = 9;
  localparam int RANK_SPLIT = 28;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic takeM;
    logic takeS;
    logic takeV;
  } route_strb_t;

  function automatic logic [7:0] default_rank(input int irq);
    int r;
    if (irq >= 48)      r = 67 - irq;
    else if (irq >= 32) r = 87 - irq;
    else if (irq >= 24) r = 51 - irq;
    else if (irq >= 16) r = 79 - irq;
    else begin
      case (irq)
        11: r = 28;
        3:  r = 29;
        7:  r = 30;
        9:  r = 31;
        1:  r = 32;
        5:  r = 33;
        12: r = 34;
        2:  r = 36;
        6:  r = 37;
        default: r = 35;
      endcase
    end
    return 8'(r);
  endfunction

  function automatic logic vs_slot_open(input int irq);
    return (irq == 1) || (irq == 5) || (irq >= 13 && irq <= 16) ||
           (irq >= 18 && irq <= 30 && (irq % 2) == 0);
  endfunction
endpackage

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter import irq_route_pkg::*; #(
  parameter int N      = NUM_IRQ,
  parameter int IW     = IDX_W,
  parameter int PW     = PRIO_W
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][PW-1:0] prioTab,
  output logic                 winValid,
  output logic [IW-1:0]        winIdx
);
  logic [N-1:0][PW-1:0] effP;
  logic [PW:0]          bestP;

  for (genvar i = 0; i < N; i++) begin : g_eff
    localparam bit RANK_HI = (int'(default_rank(i)) < RANK_SPLIT);
    assign effP[i] = (prioTab[i] != '0) ? prioTab[i]
                                       : (RANK_HI ? PW'(1) : {PW{1'b1}});
  end

  always_comb begin
    bestP  = '1;
    winIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && ({1'b0, effP[i]} < bestP)) begin
        bestP  = {1'b0, effP[i]};
        winIdx = IW'(i);
      end
    end
    winValid = |cand;
  end

  always_comb begin
    if (winValid) begin
      // R6
      arb_pick_chk: assert (cand[winIdx]);
    end
  end
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store import irq_route_pkg::*; #(
  parameter int N  = NUM_IRQ,
  parameter int IW = IDX_W,
  parameter int PW = PRIO_W,
  parameter int L  = LVLS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [1:0]                  wrLvl,
  input  logic [IW-1:0]               wrIdx,
  input  logic [PW-1:0]               wrData,
  output logic [L-1:0][N-1:0][PW-1:0] tab
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        tab[LVL_M][i] <= (i == M_EXT_IRQ) ? '0 : PW'(default_rank(i));
        tab[LVL_S][i] <= (i == S_EXT_IRQ) ? '0 : PW'(default_rank(i));
        tab[LVL_V][i] <= vs_slot_open(i) ? PW'(default_rank(i)) : '0;
      end
    end else if (wrEn) begin
      case (wrLvl)
        2'd0: tab[LVL_M][wrIdx] <= wrData;
        2'd1: tab[LVL_S][wrIdx] <= wrData;
        2'd2: if (vs_slot_open(int'(wrIdx))) tab[LVL_V][wrIdx] <= wrData;
        default: ;
      endcase
    end
  end

  // R9
  vs_closed_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrLvl == 2'd2 && !vs_slot_open(int'(wrIdx))) |=> $stable(tab[LVL_V]));

  // R10
  no_table_lvl3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrLvl == 2'd3) |=> $stable(tab));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl import irq_route_pkg::*; #(
  parameter int N  = NUM_IRQ,
  parameter int GN = NUM_IRQ,
  localparam int GSW = $clog2(GN)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   pendVec,
  input  logic [N-1:0]   enVec,
  input  logic [N-1:0]   mDeleg,
  input  logic [N-1:0]   hDeleg,
  input  logic [1:0]     privLvl,
  input  logic           virtOn,
  input  logic           mGlobalEn,
  input  logic           sGlobalEn,
  input  logic [GN-1:0]  guestExtVec,
  input  logic [GSW-1:0] guestSel,
  output logic [N-1:0]   mCand,
  output logic [N-1:0]   sCand,
  output logic [N-1:0]   vCandSh,
  output route_strb_t    strb
);
  logic         vsExt;
  logic [N-1:0] eligible;
  logic [N-1:0] vRaw;
  logic         mOn, sOn, vOn;
  logic         sLocalOk;

  assign vsExt    = guestExtVec[guestSel];
  assign eligible = (pendVec | (N'(vsExt) << VS_EXT_IRQ)) & enVec;
  assign sLocalOk = (privLvl < PRIV_S) || (privLvl == PRIV_S && sGlobalEn);

  always_comb begin
    if (virtOn) begin
      mOn = 1'b1;
      sOn = 1'b1;
      vOn = sLocalOk;
    end else begin
      mOn = (privLvl < PRIV_M) || (privLvl == PRIV_M && mGlobalEn);
      sOn = sLocalOk;
      vOn = 1'b0;
    end
  end

  assign mCand   = eligible & ~mDeleg & {N{mOn}};
  assign sCand   = eligible & mDeleg & ~hDeleg & {N{sOn}};
  assign vRaw    = eligible & mDeleg & hDeleg & {N{vOn}};
  assign vCandSh = vRaw >> 1;

  assign strb.takeM = |mCand;
  assign strb.takeS = !strb.takeM && (|sCand);
  assign strb.takeV = !strb.takeM && !strb.takeS && (|vRaw);

  // R2
  virt_off_no_vs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !virtOn |-> !strb.takeV);

  // R3
  virt_on_m_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (virtOn && ((pendVec & enVec & ~mDeleg) != '0)) |-> strb.takeM);
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp import irq_route_pkg::*; #(
  parameter int N  = NUM_IRQ,
  parameter int IW = IDX_W,
  parameter int PW = PRIO_W,
  localparam int L = LVLS
) (
  input  logic          clk,
  input  logic          rstN,
  input  route_strb_t   strb,
  input  logic [N-1:0]  mCand,
  input  logic [N-1:0]  sCand,
  input  logic [N-1:0]  vCandSh,
  input  logic          wrEn,
  input  logic [1:0]    wrLvl,
  input  logic [IW-1:0] wrIdx,
  input  logic [PW-1:0] wrData,
  output logic          irqValid,
  output logic [IW-1:0] irqNum
);
  logic [L-1:0][N-1:0][PW-1:0] tab;
  logic [L-1:0][N-1:0]         lvlCand;
  logic [L-1:0]                winValid;
  logic [L-1:0][IW-1:0]        winIdx;
  logic                        nxtValid;
  logic [IW-1:0]               nxtNum;
  logic [N-1:0]                candUnion;
  logic [N-1:0]                candQ;

  irq_prio_store #(.N(N), .IW(IW), .PW(PW), .L(L)) u_store (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLvl(wrLvl),
    .wrIdx(wrIdx), .wrData(wrData), .tab(tab)
  );

  assign lvlCand[LVL_M] = mCand;
  assign lvlCand[LVL_S] = sCand;
  assign lvlCand[LVL_V] = vCandSh;

  for (genvar g = 0; g < L; g++) begin : g_arb
    irq_prio_arbiter #(.N(N), .IW(IW), .PW(PW)) u_arb (
      .cand(lvlCand[g]), .prioTab(tab[g]),
      .winValid(winValid[g]), .winIdx(winIdx[g])
    );
  end

  always_comb begin
    nxtValid = 1'b0;
    nxtNum   = '0;
    if (strb.takeM) begin
      nxtValid = winValid[LVL_M];
      nxtNum   = winIdx[LVL_M];
    end else if (strb.takeS) begin
      nxtValid = winValid[LVL_S];
      nxtNum   = winIdx[LVL_S];
    end else if (strb.takeV) begin
      nxtValid = winValid[LVL_V];
      nxtNum   = (winIdx[LVL_V] == '0) ? '0 : winIdx[LVL_V] + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqNum   <= '0;
    end else begin
      irqValid <= nxtValid;
      irqNum   <= nxtValid ? nxtNum : '0;
    end
  end

  assign candUnion = mCand | sCand | (vCandSh << 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) candQ <= '0;
    else       candQ <= candUnion;
  end

  // R5
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.takeM || strb.takeS || strb.takeV) |=> !irqValid);

  // R4
  win_was_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && irqNum != '0) |-> candQ[irqNum]);

  // R7
  vs_never_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeV |=> (irqNum != IW'(1)));
endmodule

// File: rtl/irq_route_select.sv
module irq_route_select import irq_route_pkg::*; #(
  parameter int N  = NUM_IRQ,
  parameter int GN = NUM_IRQ,
  parameter int IW = IDX_W,
  parameter int PW = PRIO_W,
  localparam int GSW = $clog2(GN)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   pendVec,
  input  logic [N-1:0]   enVec,
  input  logic [N-1:0]   mDeleg,
  input  logic [N-1:0]   hDeleg,
  input  logic [1:0]     privLvl,
  input  logic           virtOn,
  input  logic           mGlobalEn,
  input  logic           sGlobalEn,
  input  logic [GN-1:0]  guestExtVec,
  input  logic [GSW-1:0] guestSel,
  input  logic           prioWrEn,
  input  logic [1:0]     prioWrLvl,
  input  logic [IW-1:0]  prioWrIdx,
  input  logic [PW-1:0]  prioWrData,
  output logic           irqValid,
  output logic [IW-1:0]  irqNum
);
  route_strb_t  strb;
  logic [N-1:0] mCand, sCand, vCandSh;

  irq_route_ctrl #(.N(N), .GN(GN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enVec(enVec),
    .mDeleg(mDeleg), .hDeleg(hDeleg), .privLvl(privLvl), .virtOn(virtOn),
    .mGlobalEn(mGlobalEn), .sGlobalEn(sGlobalEn),
    .guestExtVec(guestExtVec), .guestSel(guestSel),
    .mCand(mCand), .sCand(sCand), .vCandSh(vCandSh), .strb(strb)
  );

  irq_route_dp #(.N(N), .IW(IW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .mCand(mCand), .sCand(sCand), .vCandSh(vCandSh),
    .wrEn(prioWrEn), .wrLvl(prioWrLvl), .wrIdx(prioWrIdx), .wrData(prioWrData),
    .irqValid(irqValid), .irqNum(irqNum)
  );
endmodule

// File: tb/irq_route_select_test.sv
module irq_route_select_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] pendVec = '0, enVec = '0, mDeleg = '0, hDeleg = '0, guestExtVec = '0;
  logic [1:0]  privLvl = '0;
  logic        virtOn = 1'b0, mGlobalEn = 1'b0, sGlobalEn = 1'b0;
  logic [5:0]  guestSel = '0;
  logic        prioWrEn = 1'b0;
  logic [1:0]  prioWrLvl = '0;
  logic [5:0]  prioWrIdx = '0;
  logic [7:0]  prioWrData = '0;
  logic        irqValid;
  logic [5:0]  irqNum;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { bit v; int n; string tag; } exp_t;
  exp_t q[$];

  int mP[64], sP[64], vP[64];

  always #(CLK_P/2) clk = ~clk;

  irq_route_select uut (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enVec(enVec), .mDeleg(mDeleg),
    .hDeleg(hDeleg), .privLvl(privLvl), .virtOn(virtOn), .mGlobalEn(mGlobalEn),
    .sGlobalEn(sGlobalEn), .guestExtVec(guestExtVec), .guestSel(guestSel),
    .prioWrEn(prioWrEn), .prioWrLvl(prioWrLvl), .prioWrIdx(prioWrIdx),
    .prioWrData(prioWrData), .irqValid(irqValid), .irqNum(irqNum)
  );

  // rank table as given in R8
  function automatic int rankOf(int i);
    if (i >= 48) return 67 - i;
    if (i >= 32) return 87 - i;
    if (i >= 24) return 51 - i;
    if (i >= 16) return 79 - i;
    case (i)
      11: return 28; 3: return 29; 7: return 30; 9: return 31; 1: return 32;
      5: return 33; 12: return 34; 2: return 36; 6: return 37;
      default: return 35;
    endcase
  endfunction

  // writable virtual slots per R9
  function automatic bit vOpen(int i);
    return i == 1 || i == 5 || i == 13 || i == 14 || i == 15 || i == 16 ||
           i == 18 || i == 20 || i == 22 || i == 24 || i == 26 || i == 28 || i == 30;
  endfunction

  function automatic int pick(logic [63:0] c, int lvl);
    int best = -1;
    int bp = 1000;
    for (int i = 0; i < 64; i++) begin
      if (c[i]) begin
        int v = (lvl == 0) ? mP[i] : (lvl == 1) ? sP[i] : vP[i];
        if (v == 0) v = (rankOf(i) < 28) ? 1 : 255;
        if (v < bp) begin bp = v; best = i; end
      end
    end
    return best;
  endfunction

  function automatic void model(output bit ev, output int en);
    logic [63:0] el, mc, sc, vc;
    bit mo, so, vo, sl;
    int w;
    el = (pendVec | (guestExtVec[guestSel] ? 64'h400 : 64'h0)) & enVec;
    sl = (privLvl == 2'd0) || (privLvl == 2'd1 && sGlobalEn);
    if (virtOn) begin mo = 1; so = 1; vo = sl; end
    else begin mo = (privLvl != 2'd3) || mGlobalEn; so = sl; vo = 0; end
    mc = mo ? (el & ~mDeleg) : '0;
    sc = so ? (el & mDeleg & ~hDeleg) : '0;
    vc = vo ? (el & mDeleg & hDeleg) : '0;
    ev = 0; en = 0;
    if (mc != 0) begin ev = 1; en = pick(mc, 0); end
    else if (sc != 0) begin ev = 1; en = pick(sc, 1); end
    else if (vc != 0) begin
      w = pick(vc >> 1, 2);
      if (w >= 0) begin ev = 1; en = (w == 0) ? 0 : w + 1; end
    end
  endfunction

  task automatic drive(input logic [63:0] p, e, md, hd, input logic [1:0] pv,
                       input bit vo, mi, si, input logic [63:0] g,
                       input logic [5:0] gs, input string tag);
    exp_t x;
    @(negedge clk);
    pendVec = p; enVec = e; mDeleg = md; hDeleg = hd; privLvl = pv;
    virtOn = vo; mGlobalEn = mi; sGlobalEn = si; guestExtVec = g; guestSel = gs;
    prioWrEn = 0;
    model(x.v, x.n);
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic wprio(input logic [1:0] lvl, input logic [5:0] idx, input logic [7:0] d);
    @(negedge clk);
    prioWrEn = 1; prioWrLvl = lvl; prioWrIdx = idx; prioWrData = d;
    if (lvl == 0) mP[idx] = d;
    else if (lvl == 1) sP[idx] = d;
    else if (lvl == 2 && vOpen(idx)) vP[idx] = d;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      total++;
      if (irqValid !== x.v || (x.v && irqNum !== 6'(x.n))) begin
        bad++;
        $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
                 x.tag, irqValid, irqNum, x.v, x.n);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [63:0] ALL = '1;
  localparam logic [63:0] NONE = '0;

  initial begin
    for (int i = 0; i < 64; i++) begin
      mP[i] = (i == 11) ? 0 : rankOf(i);
      sP[i] = (i == 9) ? 0 : rankOf(i);
      vP[i] = vOpen(i) ? rankOf(i) : 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    total++;  // R11 reset state
    if (irqValid !== 1'b0 || irqNum !== 6'd0) begin
      bad++;
      $display("FAIL R11: got valid=%0b num=%0d, expected valid=0 num=0", irqValid, irqNum);
    end

    // R1 derived bit and enable masking
    drive(NONE, ALL, NONE, NONE, 2'd0, 0, 0, 0, 64'h20, 6'd5, "R1");
    drive(NONE, ALL, NONE, NONE, 2'd0, 0, 0, 0, 64'h20, 6'd6, "R1");
    drive(64'h80, ~64'h80, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R1");
    // R2 virt off
    drive(64'h80, ALL, NONE, NONE, 2'd3, 0, 0, 1, NONE, 6'd0, "R2");
    drive(64'h80, ALL, NONE, NONE, 2'd3, 0, 1, 0, NONE, 6'd0, "R2");
    drive(64'h80, ALL, NONE, NONE, 2'd1, 0, 0, 0, NONE, 6'd0, "R2");
    drive(64'h20, ALL, 64'h20, NONE, 2'd1, 0, 1, 0, NONE, 6'd0, "R2");
    drive(64'h20, ALL, 64'h20, NONE, 2'd1, 0, 0, 1, NONE, 6'd0, "R2");
    drive(64'h20, ALL, 64'h20, NONE, 2'd3, 0, 1, 1, NONE, 6'd0, "R2");
    drive(64'h20, ALL, 64'h20, NONE, 2'd2, 0, 1, 1, NONE, 6'd0, "R2");
    drive(64'h40, ALL, 64'h40, 64'h40, 2'd0, 0, 1, 1, NONE, 6'd0, "R2");
    // R3 virt on
    drive(64'h80, ALL, NONE, NONE, 2'd3, 1, 0, 0, NONE, 6'd0, "R3");
    drive(64'h20, ALL, 64'h20, NONE, 2'd3, 1, 0, 0, NONE, 6'd0, "R3");
    drive(64'h40, ALL, 64'h40, 64'h40, 2'd1, 1, 0, 0, NONE, 6'd0, "R3");
    drive(64'h40, ALL, 64'h40, 64'h40, 2'd1, 1, 0, 1, NONE, 6'd0, "R3");
    drive(64'h40, ALL, 64'h40, 64'h40, 2'd0, 1, 0, 0, NONE, 6'd0, "R3");
    // R4 R5 level precedence
    drive(64'hE0, ALL, 64'h60, 64'h40, 2'd0, 1, 0, 0, NONE, 6'd0, "R5");
    drive(64'h60, ALL, 64'h60, 64'h40, 2'd0, 1, 0, 0, NONE, 6'd0, "R4");
    drive(64'h8000_0000_0000_0040, ALL, 64'h40, 64'h40, 2'd0, 1, 0, 0, NONE, 6'd0, "R5");
    drive(NONE, ALL, NONE, NONE, 2'd0, 1, 1, 1, NONE, 6'd0, "R5");
    // R8 default ranks
    drive(64'h88, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R8");
    drive(64'h808, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R8");
    drive(64'h880, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R8");
    drive(64'h8000_0000_0000_0008, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R8");
    drive(64'h0000_0001_0001_0000, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R8");
    drive(64'h202, ALL, 64'h202, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R8");
    drive(64'h88, ALL, 64'h88, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R8");
    // R7 virtual shift
    drive(64'h44, ALL, ALL, ALL, 2'd0, 1, 0, 0, NONE, 6'd0, "R7");
    drive(64'h2, ALL, ALL, ALL, 2'd0, 1, 0, 0, NONE, 6'd0, "R7");
    drive(64'h1, ALL, ALL, ALL, 2'd0, 1, 0, 0, NONE, 6'd0, "R7");
    drive(64'h4, ALL, ALL, ALL, 2'd0, 1, 0, 0, 64'h1, 6'd0, "R7");
    // R9 closed virtual slot
    wprio(2'd2, 6'd4, 8'd1);
    drive(64'h24, ALL, ALL, ALL, 2'd0, 1, 0, 0, NONE, 6'd0, "R9");
    wprio(2'd2, 6'd5, 8'd1);
    drive(64'h44, ALL, ALL, ALL, 2'd0, 1, 0, 0, NONE, 6'd0, "R9");
    // R10 writes
    wprio(2'd3, 6'd7, 8'd1);
    drive(64'h88, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R10");
    wprio(2'd0, 6'd7, 8'd1);
    drive(64'h88, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R10");
    drive(64'h88, ALL, 64'h88, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R10");
    // R6 ties
    wprio(2'd0, 6'd3, 8'd1);
    drive(64'h88, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R6");
    wprio(2'd0, 6'd63, 8'd0);
    drive(64'h8000_0000_0000_0008, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R6");
    drive(64'h8000_0000_0000_0800, ALL, NONE, NONE, 2'd0, 0, 0, 0, NONE, 6'd0, "R6");

    // randomized mix
    for (int k = 0; k < 600; k++) begin
      if (k % 7 == 3) begin
        wprio(2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)),
              ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom));
      end else begin
        logic [63:0] p, e, md, hd, g;
        p  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        e  = ~({$urandom, $urandom} & {$urandom, $urandom});
        md = {$urandom, $urandom};
        hd = {$urandom, $urandom};
        g  = {$urandom, $urandom};
        drive(p, e, md, hd, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
              1'($urandom), g, 6'($urandom), "R6 random");
      end
    end

    @(negedge clk);
    prioWrEn = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule